// File: doc/BRIEF.md
# LPC Host Cycle Generator

This block sits on the host side of a low-pin-count bus. It turns one request into a complete bus cycle on a 4-bit shared address/data path. A request gives the cycle kind, an address, write data, a transfer size and DMA channel fields. The block drives a frame strobe and the start nibble, then the cycle header. It passes the bus to the peripheral through a two-clock turnaround and follows the peripheral's sync codes until the cycle finishes. It returns read data and a one-clock completion pulse with error and timeout flags.

The block covers I/O, memory, firmware and DMA cycles, in both directions. DMA cycles carry a channel/terminal-count nibble and a size nibble in place of an address. In a multi-byte host-to-peripheral DMA transfer, each byte has its own turnaround and sync exchange. A run of short-wait sync codes that is too long makes the host abort the cycle.

Top module: `lpc_host_cyc`

## Requirements
- R1: After reset, and whenever no cycle is in progress, `bus_frame` and `bus_ad_oe` are low, `rsp_done` is low and `req_busy` is low.
- R2: A cycle begins with one clock in which `bus_frame` is high and `bus_ad_oe` is high. The start nibble is 0xD for a firmware read, 0xE for a firmware write, and 0x0 for every other kind. `bus_frame` is high at no other time except during an abort.
- R3: Non-firmware cycles send a cycle-type nibble next: I/O read 0x0, I/O write 0x2, memory read 0x4, memory write 0x6, DMA host-to-peripheral 0x8, DMA peripheral-to-host 0xA. Firmware cycles send no cycle-type nibble.
- R4: I/O cycles send `req_addr[15:0]` as 4 nibbles. Memory and firmware cycles send `req_addr[31:0]` as 8 nibbles. The most significant nibble goes first.
- R5: A DMA cycle sends `{req_dma_tc, req_dma_chan}` as one nibble, then a size nibble. A firmware cycle sends a size nibble after its address. `req_size` 0 and 1 encode as 0x0 and 0x1 (1 and 2 bytes). `req_size` 2 or 3 means 4 bytes and encodes as 0x3 for DMA and 0x2 for firmware. I/O and memory cycles always move one byte.
- R6: Write data goes out starting with byte 0 (`req_wdata[7:0]`), with the low nibble of each byte before its high nibble. A non-DMA write sends all of its bytes before the turnaround.
- R7: Each hand-over from host to peripheral takes two clocks: one clock driving 0xF with `bus_ad_oe` high, then one clock with `bus_ad_oe` low. Each hand-back takes two peripheral-driven clocks, during which the host does not drive.
- R8: While the bus is handed over, sync nibble 0x5 (short wait) or 0x6 (long wait) keeps the host waiting, and 0x0 (ready) ends the wait. On a read, each byte has its own sync, followed by two data nibbles, low nibble first. These land in `rsp_rdata` from byte 0 upward, and bytes that were not read stay zero.
- R9: A multi-byte DMA host-to-peripheral transfer repeats the sequence data, turnaround, sync, turnaround for every byte. The next byte is driven in the clock after the peripheral's hand-back.
- R10: Any sync nibble other than 0x0, 0x5 and 0x6 is an error. The two hand-back clocks follow, then the cycle completes with `rsp_err` high, and no further bytes are moved.
- R11: `WAIT_LIMIT` consecutive short-wait codes make the host abort. It holds `bus_frame` high and drives 0xF for `ABORT_CLKS` clocks, then completes with `rsp_err` and `rsp_tmo` high. A long-wait code resets the count, and so does each new sync phase. `WAIT_LIMIT`-1 consecutive short waits followed by ready do not abort.
- R12: `rsp_done` pulses for one clock, in the clock after the cycle's last bus clock. `req_busy` is high from the clock after an accepted `req_go` until the clock of that pulse. A `req_go` that arrives while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_go | input | 1 | Start a cycle (taken only when idle) |
| req_kind | input | 3 | 0 I/O rd, 1 I/O wr, 2 mem rd, 3 mem wr, 4 fw rd, 5 fw wr, 6 DMA periph-to-host, 7 DMA host-to-periph |
| req_addr | input | 32 | Cycle address |
| req_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| req_size | input | 2 | Size for firmware/DMA: 0 one byte, 1 two, 2/3 four |
| req_dma_chan | input | 3 | DMA channel number |
| req_dma_tc | input | 1 | DMA terminal-count flag |
| req_busy | output | 1 | A cycle is in progress |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Completed cycle ended in error or abort |
| rsp_tmo | output | 1 | Completed cycle was aborted on wait limit |
| rsp_rdata | output | 32 | Read data, byte 0 in bits 7:0 |
| bus_frame | output | 1 | Frame strobe, active high |
| bus_ad_o | output | 4 | Address/data nibble driven by the host |
| bus_ad_oe | output | 1 | Host drive enable for the nibble bus |
| bus_ad_i | input | 4 | Nibble bus as seen by the host |

## Verification
The hardest states to reach are the ones that depend on the peripheral's pacing. These are the short-wait limit expiring at exactly its count, a long wait falling between two short-wait runs that together pass the limit, and an error code arriving in the middle of a multi-byte DMA loop. The bench builds the whole expected clock-by-clock slot script for each request, then plays the peripheral's side of that script back onto the bus. It places the directed sync patterns in a chosen sync phase and uses random wait lengths everywhere else. A `req_go` pulse is injected in the middle of a cycle to show that it has no effect.

// File: rtl/lpc_host_pkg.sv
`timescale 1ns/100ps
package lpc_host_pkg;

  typedef enum logic [2:0] {
    K_IO_RD  = 3'd0, K_IO_WR  = 3'd1,
    K_MEM_RD = 3'd2, K_MEM_WR = 3'd3,
    K_FW_RD  = 3'd4, K_FW_WR  = 3'd5,
    K_DMA_RX = 3'd6, K_DMA_TX = 3'd7
  } cyc_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_CTYPE, ST_ADDR, ST_DHDR, ST_SIZE,
    ST_HDATA, ST_HTAR1, ST_HTAR2, ST_SYNC, ST_PDATA,
    ST_PTAR1, ST_PTAR2, ST_ABORT
  } hst_state_e;

  localparam logic [3:0] START_GEN   = 4'h0;
  localparam logic [3:0] START_FWR   = 4'hD;
  localparam logic [3:0] START_FWW   = 4'hE;
  localparam logic [3:0] NIB_IDLE    = 4'hF;
  localparam logic [3:0] SYNC_READY  = 4'h0;
  localparam logic [3:0] SYNC_SHORT  = 4'h5;
  localparam logic [3:0] SYNC_LONG   = 4'h6;

  localparam int DATA_W = 32;
  localparam int NIBS   = DATA_W / 4;
  localparam int SEL_W  = $clog2(NIBS);

  function automatic logic kind_fw(cyc_kind_e k);
    return (k == K_FW_RD) || (k == K_FW_WR);
  endfunction

  function automatic logic kind_dma(cyc_kind_e k);
    return k[2] & k[1];
  endfunction

  function automatic logic kind_io(cyc_kind_e k);
    return k[2:1] == 2'b00;
  endfunction

  // odd kinds move data from host to peripheral
  function automatic logic kind_hwr(cyc_kind_e k);
    return k[0];
  endfunction

  function automatic logic [3:0] start_nib(cyc_kind_e k);
    if (k == K_FW_RD) return START_FWR;
    if (k == K_FW_WR) return START_FWW;
    return START_GEN;
  endfunction

  // DMA direction bit is taken from the host's reading side
  function automatic logic [3:0] ctype_nib(cyc_kind_e k);
    if (kind_dma(k)) return {1'b1, 1'b0, ~k[0], 1'b0};
    return {1'b0, k[1], k[0], 1'b0};
  endfunction

  function automatic logic [2:0] byte_count(cyc_kind_e k, logic [1:0] sz);
    if (!(kind_fw(k) || kind_dma(k))) return 3'd1;
    if (sz == 2'd0) return 3'd1;
    if (sz == 2'd1) return 3'd2;
    return 3'd4;
  endfunction

  function automatic logic [3:0] size_nib(cyc_kind_e k, logic [1:0] sz);
    if (sz == 2'd0) return 4'h0;
    if (sz == 2'd1) return 4'h1;
    return kind_dma(k) ? 4'h3 : 4'h2;
  endfunction

endpackage

// File: rtl/lpc_host_nib_sel.sv
`timescale 1ns/100ps
module lpc_host_nib_sel #(
  parameter int WORD_W = 32,
  localparam int NN    = WORD_W / 4,
  localparam int SW    = $clog2(NN)
) (
  input  logic [WORD_W-1:0] word,
  input  logic [SW-1:0]     sel,
  output logic [3:0]        nib
);
  logic [3:0] parts [NN];

  for (genvar g = 0; g < NN; g++) begin : g_split
    assign parts[g] = word[4*g +: 4];
  end

  assign nib = parts[sel];
endmodule

// File: rtl/lpc_host_wait_ctr.sv
`timescale 1ns/100ps
module lpc_host_wait_ctr #(
  parameter int LIMIT = 8,
  localparam int CW   = (LIMIT > 2) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic short_seen,
  output logic expire
);
  logic [CW-1:0] cnt;

  // any clock that is not a short wait restarts the run
  always_ff @(posedge clk) begin
    if (rst || !short_seen) cnt <= '0;
    else if (!expire)       cnt <= cnt + 1'b1;
  end

  assign expire = short_seen && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/lpc_host_rdcap.sv
`timescale 1ns/100ps
module lpc_host_rdcap #(
  parameter int WORD_W = 32,
  localparam int NN    = WORD_W / 4,
  localparam int SW    = $clog2(NN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              we,
  input  logic [SW-1:0]     sel,
  input  logic [3:0]        din,
  output logic [WORD_W-1:0] q
);
  for (genvar g = 0; g < NN; g++) begin : g_nib
    always_ff @(posedge clk) begin
      if (rst || clr)                  q[4*g +: 4] <= 4'h0;
      else if (we && sel == SW'(g))    q[4*g +: 4] <= din;
    end
  end
endmodule

// File: rtl/lpc_host_cyc.sv
`timescale 1ns/100ps
module lpc_host_cyc
  import lpc_host_pkg::*;
#(
  parameter int WAIT_LIMIT = 8,
  parameter int ABORT_CLKS = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_go,
  input  logic [2:0]  req_kind,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic [1:0]  req_size,
  input  logic [2:0]  req_dma_chan,
  input  logic        req_dma_tc,
  output logic        req_busy,
  output logic        rsp_done,
  output logic        rsp_err,
  output logic        rsp_tmo,
  output logic [31:0] rsp_rdata,
  output logic        bus_frame,
  output logic [3:0]  bus_ad_o,
  output logic        bus_ad_oe,
  input  logic [3:0]  bus_ad_i
);
  localparam int AW = (ABORT_CLKS > 2) ? $clog2(ABORT_CLKS) : 1;

  hst_state_e         state;
  cyc_kind_e          kind_q;
  logic [31:0]        addr_q;
  logic [31:0]        wdata_q;
  logic [1:0]         szc_q;
  logic [2:0]         nb_q;
  logic [2:0]         chan_q;
  logic               tc_q;
  logic [SEL_W-1:0]   aidx;
  logic [SEL_W:0]     dptr;
  logic [AW-1:0]      acnt;
  logic               err_q, tmo_q, done_q;

  logic [SEL_W-1:0]   last_aidx;
  logic [3:0]         addr_nib, data_nib;
  logic               last_byte, wait_expire, short_seen, take;
  logic [2:0]         bytes_done;

  assign take       = (state == ST_IDLE) && req_go;
  assign last_aidx  = kind_io(kind_q) ? SEL_W'(3) : SEL_W'(NIBS - 1);
  assign bytes_done = dptr[SEL_W:1];
  assign last_byte  = (bytes_done == nb_q - 3'd1);
  assign short_seen = (state == ST_SYNC) && (bus_ad_i == SYNC_SHORT);

  lpc_host_nib_sel #(.WORD_W(DATA_W)) u_addr_sel (
    .word (addr_q),
    .sel  (last_aidx - aidx),
    .nib  (addr_nib)
  );

  lpc_host_nib_sel #(.WORD_W(DATA_W)) u_data_sel (
    .word (wdata_q),
    .sel  (dptr[SEL_W-1:0]),
    .nib  (data_nib)
  );

  lpc_host_wait_ctr #(.LIMIT(WAIT_LIMIT)) u_wait (
    .clk        (clk),
    .rst        (rst),
    .short_seen (short_seen),
    .expire     (wait_expire)
  );

  lpc_host_rdcap #(.WORD_W(DATA_W)) u_rdcap (
    .clk (clk),
    .rst (rst),
    .clr (take),
    .we  (state == ST_PDATA),
    .sel (dptr[SEL_W-1:0]),
    .din (bus_ad_i),
    .q   (rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      kind_q  <= K_IO_RD;
      addr_q  <= '0;
      wdata_q <= '0;
      szc_q   <= '0;
      nb_q    <= 3'd1;
      chan_q  <= '0;
      tc_q    <= 1'b0;
      aidx    <= '0;
      dptr    <= '0;
      acnt    <= '0;
      err_q   <= 1'b0;
      tmo_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (req_go) begin
          kind_q  <= cyc_kind_e'(req_kind);
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          szc_q   <= req_size;
          nb_q    <= byte_count(cyc_kind_e'(req_kind), req_size);
          chan_q  <= req_dma_chan;
          tc_q    <= req_dma_tc;
          aidx    <= '0;
          dptr    <= '0;
          acnt    <= '0;
          err_q   <= 1'b0;
          tmo_q   <= 1'b0;
          state   <= ST_START;
        end
        ST_START: state <= kind_fw(kind_q) ? ST_ADDR : ST_CTYPE;
        ST_CTYPE: state <= kind_dma(kind_q) ? ST_DHDR : ST_ADDR;
        ST_ADDR: begin
          aidx <= aidx + 1'b1;
          if (aidx == last_aidx) begin
            if (kind_fw(kind_q))       state <= ST_SIZE;
            else if (kind_hwr(kind_q)) state <= ST_HDATA;
            else                       state <= ST_HTAR1;
          end
        end
        ST_DHDR: state <= ST_SIZE;
        ST_SIZE: state <= kind_hwr(kind_q) ? ST_HDATA : ST_HTAR1;
        ST_HDATA: begin
          dptr <= dptr + 1'b1;
          if (dptr[0] && (kind_dma(kind_q) || last_byte)) state <= ST_HTAR1;
        end
        ST_HTAR1: state <= ST_HTAR2;
        ST_HTAR2: state <= ST_SYNC;
        ST_SYNC: begin
          if (bus_ad_i == SYNC_READY)
            state <= kind_hwr(kind_q) ? ST_PTAR1 : ST_PDATA;
          else if (bus_ad_i == SYNC_SHORT) begin
            if (wait_expire) state <= ST_ABORT;
          end else if (bus_ad_i != SYNC_LONG) begin
            err_q <= 1'b1;
            state <= ST_PTAR1;
          end
        end
        ST_PDATA: begin
          dptr <= dptr + 1'b1;
          if (dptr[0]) state <= last_byte ? ST_PTAR1 : ST_SYNC;
        end
        ST_PTAR1: state <= ST_PTAR2;
        ST_PTAR2: begin
          if (!err_q && kind_dma(kind_q) && kind_hwr(kind_q) && bytes_done != nb_q)
            state <= ST_HDATA;
          else begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        ST_ABORT: begin
          acnt <= acnt + 1'b1;
          if (acnt == AW'(ABORT_CLKS - 1)) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
            err_q  <= 1'b1;
            tmo_q  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_frame = 1'b0;
    bus_ad_oe = 1'b0;
    bus_ad_o  = NIB_IDLE;
    case (state)
      ST_START: begin bus_frame = 1'b1; bus_ad_oe = 1'b1; bus_ad_o = start_nib(kind_q); end
      ST_CTYPE: begin bus_ad_oe = 1'b1; bus_ad_o = ctype_nib(kind_q); end
      ST_ADDR:  begin bus_ad_oe = 1'b1; bus_ad_o = addr_nib; end
      ST_DHDR:  begin bus_ad_oe = 1'b1; bus_ad_o = {tc_q, chan_q}; end
      ST_SIZE:  begin bus_ad_oe = 1'b1; bus_ad_o = size_nib(kind_q, szc_q); end
      ST_HDATA: begin bus_ad_oe = 1'b1; bus_ad_o = data_nib; end
      ST_HTAR1: begin bus_ad_oe = 1'b1; bus_ad_o = NIB_IDLE; end
      ST_ABORT: begin bus_frame = 1'b1; bus_ad_oe = 1'b1; bus_ad_o = NIB_IDLE; end
      default: ;
    endcase
  end

  assign req_busy = (state != ST_IDLE);
  assign rsp_done = done_q;
  assign rsp_err  = err_q;
  assign rsp_tmo  = tmo_q;
endmodule

// File: rtl/lpc_host_chk.sv
`timescale 1ns/100ps
module lpc_host_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       tmo,
  input logic       frame,
  input logic       oe,
  input logic [3:0] ad
);
  // R1: an idle host leaves the bus alone
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!oe && !frame));

  // R2: the strobe only appears while driving a start or abort pattern
  p_frame_code_r2: assert property (@(posedge clk) disable iff (rst)
    frame |-> (oe && (ad == 4'h0 || ad == 4'hD || ad == 4'hE || ad == 4'hF)));

  // R7: host always releases the bus from an all-ones nibble
  p_release_ones_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(oe) && !oe) |-> ($past(ad) == 4'hF));

  // R12: completion is a single-clock pulse seen with the host idle
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R11: a timeout is always reported as an error too
  p_tmo_err_r11: assert property (@(posedge clk) disable iff (rst)
    (done && tmo) |-> err);
endmodule

bind lpc_host_cyc lpc_host_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .busy  (req_busy),
  .done  (rsp_done),
  .err   (rsp_err),
  .tmo   (rsp_tmo),
  .frame (bus_frame),
  .oe    (bus_ad_oe),
  .ad    (bus_ad_o)
);

// File: tb/lpc_host_cyc_tb.sv
`timescale 1ns/100ps
module lpc_host_cyc_tb;
  localparam int LIM = 8;
  localparam int ABT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_go = 1'b0;
  logic [2:0]  req_kind = '0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_size = '0;
  logic [2:0]  req_dma_chan = '0;
  logic        req_dma_tc = 1'b0;
  logic        req_busy, rsp_done, rsp_err, rsp_tmo;
  logic [31:0] rsp_rdata;
  logic        bus_frame, bus_ad_oe;
  logic [3:0]  bus_ad_o;
  logic [3:0]  bus_ad_i = 4'hF;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  lpc_host_cyc #(.WAIT_LIMIT(LIM), .ABORT_CLKS(ABT)) u_dut (
    .clk(clk), .rst(rst), .req_go(req_go), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_size(req_size),
    .req_dma_chan(req_dma_chan), .req_dma_tc(req_dma_tc),
    .req_busy(req_busy), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .rsp_tmo(rsp_tmo), .rsp_rdata(rsp_rdata), .bus_frame(bus_frame),
    .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe), .bus_ad_i(bus_ad_i)
  );

  // slot kinds: 0 host drives, 1 host floats, 2 peripheral drives
  logic [1:0]  s_typ [256];
  logic [3:0]  s_val [256];
  logic        s_frm [256];
  int          n_slot;
  logic [31:0] e_rdata;
  logic        e_err, e_tmo;

  task automatic put(input logic [1:0] t, input logic [3:0] v, input logic f);
    s_typ[n_slot] = t; s_val[n_slot] = v; s_frm[n_slot] = f;
    n_slot++;
  endtask

  task automatic put_htar();
    put(2'd0, 4'hF, 1'b0); put(2'd1, 4'hF, 1'b0);
  endtask

  task automatic put_ptar();
    put(2'd2, 4'hF, 1'b0); put(2'd2, 4'hF, 1'b0);
  endtask

  // mode 0 random waits, 1 error code, 2 timeout, 3 one short of limit, 4 long wait splits run
  task automatic put_sync(input int mode, output int res);
    int nw;
    res = 0;
    case (mode)
      1: begin
        nw = $urandom_range(0, 3);
        repeat (nw) put(2'd2, 4'h6, 1'b0);
        put(2'd2, 4'hA, 1'b0); res = 1; e_err = 1'b1;
      end
      2: begin
        repeat (LIM) put(2'd2, 4'h5, 1'b0);
        repeat (ABT) put(2'd0, 4'hF, 1'b1);
        res = 2; e_err = 1'b1; e_tmo = 1'b1;
      end
      3: begin
        repeat (LIM - 1) put(2'd2, 4'h5, 1'b0);
        put(2'd2, 4'h0, 1'b0);
      end
      4: begin
        repeat (LIM - 2) put(2'd2, 4'h5, 1'b0);
        put(2'd2, 4'h6, 1'b0);
        repeat (LIM - 2) put(2'd2, 4'h5, 1'b0);
        put(2'd2, 4'h0, 1'b0);
      end
      default: begin
        nw = $urandom_range(0, 4);
        for (int i = 0; i < nw; i++) put(2'd2, ($urandom_range(0, 1) != 0) ? 4'h5 : 4'h6, 1'b0);
        put(2'd2, 4'h0, 1'b0);
      end
    endcase
  endtask

  task automatic build(input int k, input logic [31:0] a, input logic [31:0] wd,
                       input logic [31:0] rd, input int sz, input logic [2:0] ch,
                       input logic tc, input int sidx, input int smode);
    int nb, nn, si, res;
    bit fw, dma, wr, gen;
    n_slot = 0; e_rdata = '0; e_err = 1'b0; e_tmo = 1'b0; si = 0;
    fw = (k == 4 || k == 5); dma = (k >= 6); wr = (k % 2 == 1); gen = (k < 4);
    nb = gen ? 1 : (sz == 0 ? 1 : (sz == 1 ? 2 : 4));
    put(2'd0, fw ? ((k == 4) ? 4'hD : 4'hE) : 4'h0, 1'b1);
    if (!fw) put(2'd0, dma ? {1'b1, 1'b0, ~wr, 1'b0} : {1'b0, (k >= 2), wr, 1'b0}, 1'b0);
    if (!dma) begin
      nn = (k < 2) ? 4 : 8;
      for (int i = 0; i < nn; i++) put(2'd0, a[4*(nn-1-i) +: 4], 1'b0);
    end else put(2'd0, {tc, ch}, 1'b0);
    if (fw || dma) put(2'd0, (sz == 0) ? 4'h0 : (sz == 1) ? 4'h1 : (dma ? 4'h3 : 4'h2), 1'b0);
    if (wr && !dma) begin
      for (int b = 0; b < nb; b++) begin
        put(2'd0, wd[8*b +: 4], 1'b0); put(2'd0, wd[8*b+4 +: 4], 1'b0);
      end
      put_htar();
      put_sync((si == sidx) ? smode : 0, res);
      if (res != 2) put_ptar();
    end else if (wr) begin
      for (int b = 0; b < nb; b++) begin
        put(2'd0, wd[8*b +: 4], 1'b0); put(2'd0, wd[8*b+4 +: 4], 1'b0);
        put_htar();
        put_sync((si == sidx) ? smode : 0, res); si++;
        if (res == 2) return;
        put_ptar();
        if (res == 1) return;
      end
    end else begin
      put_htar();
      for (int b = 0; b < nb; b++) begin
        put_sync((si == sidx) ? smode : 0, res); si++;
        if (res == 2) return;
        if (res == 1) begin put_ptar(); return; end
        put(2'd2, rd[8*b +: 4], 1'b0); put(2'd2, rd[8*b+4 +: 4], 1'b0);
        e_rdata[8*b +: 8] = rd[8*b +: 8];
      end
      put_ptar();
    end
  endtask

  task automatic txn(input string tag, input int k, input logic [31:0] a, input logic [31:0] wd,
                     input logic [31:0] rd, input int sz, input logic [2:0] ch, input logic tc,
                     input int sidx, input int smode, input bit poke);
    bit bad;
    build(k, a, wd, rd, sz, ch, tc, sidx, smode);
    @(negedge clk);
    req_kind = 3'(k); req_addr = a; req_wdata = wd; req_size = 2'(sz);
    req_dma_chan = ch; req_dma_tc = tc; req_go = 1'b1;
    @(negedge clk);
    req_go = 1'b0;
    bad = 1'b0;
    for (int i = 0; i < n_slot; i++) begin
      if (poke && i == 2) begin req_go = 1'b1; req_kind = 3'($urandom_range(0, 7)); req_addr = $urandom; end
      if (poke && i == 3) req_go = 1'b0;
      bus_ad_i = (s_typ[i] == 2'd2) ? s_val[i] : 4'hF;
      if (!bad) begin
        if (s_typ[i] == 2'd0 && (bus_ad_oe !== 1'b1 || bus_ad_o !== s_val[i] || bus_frame !== s_frm[i])) begin
          bad = 1'b1;
          $display("FAIL %s slot %0d: oe=%b ad=%h frame=%b expected oe=1 ad=%h frame=%b",
                   tag, i, bus_ad_oe, bus_ad_o, bus_frame, s_val[i], s_frm[i]);
        end else if (s_typ[i] != 2'd0 && (bus_ad_oe !== 1'b0 || bus_frame !== 1'b0)) begin
          bad = 1'b1;
          $display("FAIL %s slot %0d: oe=%b frame=%b expected oe=0 frame=0",
                   tag, i, bus_ad_oe, bus_frame);
        end
      end
      @(negedge clk);
    end
    bus_ad_i = 4'hF;
    n_chk++;
    if (bad) n_fail++;
    n_chk++;
    if (rsp_done !== 1'b1 || rsp_err !== e_err || rsp_tmo !== e_tmo || rsp_rdata !== e_rdata) begin
      n_fail++;
      $display("FAIL %s R12 result: done=%b err=%b tmo=%b rdata=%h expected done=1 err=%b tmo=%b rdata=%h",
               tag, rsp_done, rsp_err, rsp_tmo, rsp_rdata, e_err, e_tmo, e_rdata);
    end
    @(negedge clk);
    n_chk++;
    if (rsp_done !== 1'b0 || req_busy !== 1'b0) begin
      n_fail++;
      $display("FAIL %s R12 after done: done=%b busy=%b expected 0 0", tag, rsp_done, req_busy);
    end
  endtask

  initial begin
    int seed_init;
    seed_init = $urandom(32'd4711);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_chk++;
    if (bus_frame !== 1'b0 || bus_ad_oe !== 1'b0 || rsp_done !== 1'b0 || req_busy !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: frame=%b oe=%b done=%b busy=%b expected 0 0 0 0",
               bus_frame, bus_ad_oe, rsp_done, req_busy);
    end
    // directed cases
    txn("R4 io write",      1, 32'h1234_ABCD, 32'h0000_005A, 0, 0, 0, 0, -1, 0, 0);
    txn("R8 io read",       0, 32'h0000_0F31, 0, 32'h0000_00C7, 0, 0, 0, -1, 0, 0);
    txn("R3 mem write",     3, 32'hFEDC_BA98, 32'h0000_0033, 0, 2, 0, 0, -1, 0, 0);
    txn("R3 mem read",      2, 32'h8000_0001, 0, 32'hDEAD_BE96, 2, 0, 0, -1, 0, 0);
    txn("R5 fw read 1B",    4, 32'h0011_2233, 0, 32'h0000_00E1, 0, 0, 0, -1, 0, 0);
    txn("R5 fw read 2B",    4, 32'hFFFF_0010, 0, 32'h0000_B2A1, 1, 0, 0, -1, 0, 0);
    txn("R6 fw write 4B",   5, 32'h0A0B_0C0D, 32'h8765_4321, 0, 2, 0, 0, -1, 0, 0);
    txn("R5 dma read 4B",   6, 0, 0, 32'h1357_9BDF, 3, 3'd2, 1'b0, -1, 0, 0);
    txn("R9 dma write 4B",  7, 0, 32'hCAFE_F00D, 0, 2, 3'd5, 1'b1, -1, 0, 0);
    txn("R9 dma write 2B",  7, 0, 32'h0000_9182, 0, 1, 3'd7, 1'b0, -1, 0, 0);
    txn("R10 dma write err",7, 0, 32'h4433_2211, 0, 2, 3'd1, 1'b0, 1, 1, 0);
    txn("R10 fw read err",  4, 32'h1, 0, 32'hAABB_CCDD, 2, 0, 0, 2, 1, 0);
    txn("R10 io write err", 1, 32'h60, 32'h77, 0, 0, 0, 0, 0, 1, 0);
    txn("R11 timeout",      2, 32'h4000_0000, 0, 32'h11, 0, 0, 0, 0, 2, 0);
    txn("R11 dma timeout",  6, 0, 0, 32'h5566_7788, 3, 3'd4, 1'b1, 1, 2, 0);
    txn("R11 below limit",  3, 32'h2, 32'h9, 0, 0, 0, 0, 0, 3, 0);
    txn("R11 long resets",  0, 32'h3F8, 0, 32'h42, 0, 0, 0, 0, 4, 0);
    txn("R12 go ignored",   7, 0, 32'h0102_0304, 0, 2, 3'd3, 1'b0, -1, 0, 1);
    // random traffic
    for (int n = 0; n < 50; n++) begin
      int k, sz, sm;
      k  = $urandom_range(0, 7);
      sz = $urandom_range(0, 3);
      sm = ($urandom_range(0, 7) == 0) ? 1 : (($urandom_range(0, 9) == 0) ? 2 : 0);
      txn("R8 random", k, $urandom, $urandom, $urandom, sz, 3'($urandom_range(0, 7)),
          1'($urandom_range(0, 1)), $urandom_range(0, 3), sm, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule